// File: doc/BRIEF.md
# Deep Color Pixel Gearbox

The gearbox sits between a 48-bit pixel stream and a link that carries one 8-bit symbol per channel per link cycle. A pixel holds three 16-bit components, and each component travels on its own channel. When the color depth is 10, 12 or 16 bits per component, the link needs more symbols than there are pixels. The link clock therefore runs at 1, 1.25, 1.5 or 2 times the pixel rate. A feeding FIFO absorbs that difference.

On the transmit side the packer keeps the upper D bits of each component and appends them to a per-channel bit accumulator. It emits one byte per channel in every active link cycle. It pulls the next pixel only when fewer than 8 bits are left in the accumulator. A byte phase counter tracks the position inside the repeating packing group. The packer exports that phase together with the depth code as an 8-bit control packet field.

On the receive side the unpacker consumes the depth code and rebuilds pixels from the byte stream. Both sides latch the depth code only while they are idle. Both sides restart their phase at the first cycle of every active period.

Top module: `dcg_gearbox`

## Requirements
- R1: Depth codes 0100, 0101, 0110 and 0111 select 8, 10, 12 and 16 bits per component. Any other code selects 8 bits. `tx_gcp_o[3:0]` reports the code in effect (0100 after a fallback), and `tx_gcp_o[7:4]` carries the packing phase.
- R2: For depth D, each channel's stream is the upper D bits of successive components, concatenated least significant bit first. Link byte k of a period holds stream bits 8k to 8k+7. Channel 0 is `pix_i[15:0]` on `link_sym_o[7:0]`, channel 1 is `pix_i[31:16]` on `link_sym_o[15:8]`, and channel 2 is `pix_i[47:32]` on `link_sym_o[23:16]`.
- R3: `pix_ready_o` is high, and `pix_i` is consumed at that edge, only in an active cycle whose accumulator holds fewer than 8 bits. Over n active cycles from the start of a period, exactly ceil(8n/D) pixels are consumed.
- R4: `link_valid_o` repeats `tx_en_i` one cycle later, and each byte appears on `link_sym_o` one cycle after its active cycle. `link_sym_o` is zero while `link_valid_o` is low.
- R5: The phase of link byte k in a period is k mod G, where G is 1, 5, 3 and 2 for 8, 10, 12 and 16 bits. While idle, `tx_gcp_o[7:4]` holds the phase of the last byte sent.
- R6: Each side latches its depth code only while it is idle (`tx_en_i` low or `link_valid_i` low). A code change during an active period has no effect on that period.
- R7: The unpacker outputs a pixel one cycle after the byte that completes D bits on every channel. Each component carries the received D bits in its upper bits, and its unused low bits are zero. `pix_o` is zero when `pix_valid_o` is low.
- R8: A low cycle on `link_valid_i` discards any partial bits in the unpacker and restarts its phase. `rx_phase_o` gives the phase (k mod G) of the last byte received.
- R9: After reset, no pixel is taken and no link or pixel output is valid. The reported depth code is 0100 with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_cd_i | input | 4 | Transmit depth code |
| tx_en_i | input | 1 | Active link cycle on the transmit side |
| pix_i | input | 48 | Pixel to pack, three 16-bit components |
| pix_ready_o | output | 1 | Pixel consumed at this edge |
| link_sym_o | output | 24 | Packed link bytes, one per channel |
| link_valid_o | output | 1 | Link bytes valid |
| tx_gcp_o | output | 8 | Phase in [7:4], depth code in [3:0] |
| rx_cd_i | input | 4 | Receive depth code |
| link_valid_i | input | 1 | Received link bytes valid |
| link_sym_i | input | 24 | Received link bytes |
| pix_o | output | 48 | Unpacked pixel |
| pix_valid_o | output | 1 | Unpacked pixel valid |
| rx_phase_o | output | 4 | Phase of the last received byte |

## Verification
The hardest situation to reach is an active period that stops partway through a packing group. Bits are then left stranded in both accumulators, and the next period must start cleanly at phase 0. The bench reaches it by looping the link outputs back into the receive inputs and ending a 10-bit period after 7 bytes. It then starts another 10-bit period and compares every byte and pixel against a bit-stream model that restarts on each period. A depth code switched halfway through a 12-bit period, and an illegal code, cover the latching and fallback paths at the ports.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [1:0] {DEPTH_8, DEPTH_10, DEPTH_12, DEPTH_16} depth_e;

  localparam logic [3:0] CD_8  = 4'b0100;
  localparam logic [3:0] CD_10 = 4'b0101;
  localparam logic [3:0] CD_12 = 4'b0110;
  localparam logic [3:0] CD_16 = 4'b0111;

  function automatic depth_e cd_to_depth(input logic [3:0] cd);
    case (cd)
      CD_10:   return DEPTH_10;
      CD_12:   return DEPTH_12;
      CD_16:   return DEPTH_16;
      default: return DEPTH_8;
    endcase
  endfunction

  function automatic logic [4:0] depth_bits(input depth_e d);
    case (d)
      DEPTH_10: return 5'd10;
      DEPTH_12: return 5'd12;
      DEPTH_16: return 5'd16;
      default:  return 5'd8;
    endcase
  endfunction

  // link bytes per packing group
  function automatic logic [2:0] depth_group(input depth_e d);
    case (d)
      DEPTH_10: return 3'd5;
      DEPTH_12: return 3'd3;
      DEPTH_16: return 3'd2;
      default:  return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] depth_code(input depth_e d);
    case (d)
      DEPTH_10: return CD_10;
      DEPTH_12: return CD_12;
      DEPTH_16: return CD_16;
      default:  return CD_8;
    endcase
  endfunction
endpackage

// File: rtl/dcg_depth_reg.sv
module dcg_depth_reg
  import dcg_pkg::*;
#(
  parameter int CD_W    = 4,
  parameter int BITS_W  = 5,
  parameter int PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CD_W-1:0]    cd_i,
  input  logic               busy_i,
  output logic [BITS_W-1:0]  bits_o,
  output logic [PHASE_W-1:0] group_o,
  output logic [CD_W-1:0]    code_o
);
  depth_e depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      depth_q <= DEPTH_8;
    else if (!busy_i) depth_q <= cd_to_depth(4'(cd_i));
  end

  assign bits_o  = BITS_W'(depth_bits(depth_q));
  assign group_o = PHASE_W'(depth_group(depth_q));
  assign code_o  = CD_W'(depth_code(depth_q));
endmodule

// File: rtl/dcg_pack.sv
module dcg_pack #(
  parameter int NUM_CH  = 3,
  parameter int COMP_W  = 16,
  parameter int SYM_W   = 8,
  parameter int PHASE_W = 4,
  parameter int BITS_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [BITS_W-1:0]        bits_i,
  input  logic [PHASE_W-1:0]       group_i,
  input  logic [NUM_CH*COMP_W-1:0] pix_i,
  output logic                     take_o,
  output logic [NUM_CH*SYM_W-1:0]  sym_o,
  output logic                     valid_o,
  output logic [PHASE_W-1:0]       phase_o
);
  localparam int ACC_W = COMP_W + SYM_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [CNT_W-1:0]        cnt_q, cnt_sum;
  logic [NUM_CH*SYM_W-1:0] sym_d, sym_q;
  logic [PHASE_W-1:0]      bidx_q, phase_q;
  logic                    valid_q, take;

  assign take    = en_i && (cnt_q < CNT_W'(SYM_W));
  assign cnt_sum = cnt_q + (take ? CNT_W'(bits_i) : '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [ACC_W-1:0]  acc_q, merged;
    logic [COMP_W-1:0] comp_hi;

    // keep only the upper D bits, right aligned
    assign comp_hi = pix_i[ch*COMP_W +: COMP_W] >> (BITS_W'(COMP_W) - bits_i);
    assign merged  = acc_q | (take ? (ACC_W'(comp_hi) << cnt_q) : '0);
    assign sym_d[ch*SYM_W +: SYM_W] = merged[SYM_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (en_i) acc_q <= merged >> SYM_W;
      else           acc_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bidx_q  <= '0;
      phase_q <= '0;
      sym_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en_i;
      if (en_i) begin
        cnt_q   <= cnt_sum - CNT_W'(SYM_W);
        sym_q   <= sym_d;
        phase_q <= bidx_q;
        bidx_q  <= (bidx_q == group_i - PHASE_W'(1)) ? '0 : bidx_q + PHASE_W'(1);
      end else begin
        cnt_q  <= '0;
        sym_q  <= '0;
        bidx_q <= '0;
      end
    end
  end

  assign take_o  = take;
  assign sym_o   = sym_q;
  assign valid_o = valid_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dcg_unpack.sv
module dcg_unpack #(
  parameter int NUM_CH  = 3,
  parameter int COMP_W  = 16,
  parameter int SYM_W   = 8,
  parameter int PHASE_W = 4,
  parameter int BITS_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [BITS_W-1:0]        bits_i,
  input  logic [PHASE_W-1:0]       group_i,
  input  logic [NUM_CH*SYM_W-1:0]  sym_i,
  output logic [NUM_CH*COMP_W-1:0] pix_o,
  output logic                     valid_o,
  output logic [PHASE_W-1:0]       phase_o
);
  localparam int ACC_W = COMP_W + SYM_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [CNT_W-1:0]         cnt_q, total;
  logic [NUM_CH*COMP_W-1:0] pix_d, pix_q;
  logic [PHASE_W-1:0]       bidx_q, phase_q;
  logic                     valid_q, fire;

  assign total = cnt_q + CNT_W'(SYM_W);
  assign fire  = en_i && (total >= CNT_W'(bits_i));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [ACC_W-1:0]  acc_q, merged, mask;
    logic [COMP_W-1:0] low;

    assign merged = acc_q | (ACC_W'(sym_i[ch*SYM_W +: SYM_W]) << cnt_q);
    assign mask   = (ACC_W'(1) << bits_i) - ACC_W'(1);
    assign low    = COMP_W'(merged & mask);
    // left align, unused low bits zero
    assign pix_d[ch*COMP_W +: COMP_W] = low << (BITS_W'(COMP_W) - bits_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q <= '0;
      else if (!en_i) acc_q <= '0;
      else if (fire)  acc_q <= merged >> bits_i;
      else            acc_q <= merged;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bidx_q  <= '0;
      phase_q <= '0;
      pix_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      pix_q   <= fire ? pix_d : '0;
      if (en_i) begin
        cnt_q   <= fire ? total - CNT_W'(bits_i) : total;
        phase_q <= bidx_q;
        bidx_q  <= (bidx_q == group_i - PHASE_W'(1)) ? '0 : bidx_q + PHASE_W'(1);
      end else begin
        cnt_q  <= '0;
        bidx_q <= '0;
      end
    end
  end

  assign pix_o   = pix_q;
  assign valid_o = valid_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dcg_gearbox.sv
module dcg_gearbox #(
  parameter int NUM_CH  = 3,
  parameter int COMP_W  = 16,
  parameter int SYM_W   = 8,
  parameter int CD_W    = 4,
  parameter int PHASE_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CD_W-1:0]            tx_cd_i,
  input  logic                       tx_en_i,
  input  logic [NUM_CH*COMP_W-1:0]   pix_i,
  output logic                       pix_ready_o,
  output logic [NUM_CH*SYM_W-1:0]    link_sym_o,
  output logic                       link_valid_o,
  output logic [PHASE_W+CD_W-1:0]    tx_gcp_o,
  input  logic [CD_W-1:0]            rx_cd_i,
  input  logic                       link_valid_i,
  input  logic [NUM_CH*SYM_W-1:0]    link_sym_i,
  output logic [NUM_CH*COMP_W-1:0]   pix_o,
  output logic                       pix_valid_o,
  output logic [PHASE_W-1:0]         rx_phase_o
);
  localparam int BITS_W = $clog2(COMP_W + 1);

  logic [BITS_W-1:0]  tx_bits, rx_bits;
  logic [PHASE_W-1:0] tx_group, rx_group, tx_phase;
  logic [CD_W-1:0]    tx_code, rx_code;

  dcg_depth_reg #(.CD_W(CD_W), .BITS_W(BITS_W), .PHASE_W(PHASE_W)) u_tx_depth (
    .clk_i(clk_i), .rst_ni(rst_ni), .cd_i(tx_cd_i), .busy_i(tx_en_i),
    .bits_o(tx_bits), .group_o(tx_group), .code_o(tx_code)
  );

  dcg_depth_reg #(.CD_W(CD_W), .BITS_W(BITS_W), .PHASE_W(PHASE_W)) u_rx_depth (
    .clk_i(clk_i), .rst_ni(rst_ni), .cd_i(rx_cd_i), .busy_i(link_valid_i),
    .bits_o(rx_bits), .group_o(rx_group), .code_o(rx_code)
  );

  dcg_pack #(
    .NUM_CH(NUM_CH), .COMP_W(COMP_W), .SYM_W(SYM_W), .PHASE_W(PHASE_W), .BITS_W(BITS_W)
  ) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tx_en_i), .bits_i(tx_bits), .group_i(tx_group),
    .pix_i(pix_i), .take_o(pix_ready_o), .sym_o(link_sym_o), .valid_o(link_valid_o),
    .phase_o(tx_phase)
  );

  dcg_unpack #(
    .NUM_CH(NUM_CH), .COMP_W(COMP_W), .SYM_W(SYM_W), .PHASE_W(PHASE_W), .BITS_W(BITS_W)
  ) u_unpack (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(link_valid_i), .bits_i(rx_bits),
    .group_i(rx_group), .sym_i(link_sym_i), .pix_o(pix_o), .valid_o(pix_valid_o),
    .phase_o(rx_phase_o)
  );

  assign tx_gcp_o = {tx_phase, tx_code};

  logic unused_rx_code;
  assign unused_rx_code = ^rx_code;
endmodule

// File: rtl/dcg_gearbox_chk.sv
module dcg_gearbox_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_en_i,
  input logic        pix_ready_o,
  input logic [23:0] link_sym_o,
  input logic        link_valid_o,
  input logic [7:0]  tx_gcp_o,
  input logic        link_valid_i,
  input logic        pix_valid_o,
  input logic [3:0]  rx_phase_o
);
  logic [3:0] grp;
  always_comb begin
    case (tx_gcp_o[3:0])
      4'b0101: grp = 4'd5;
      4'b0110: grp = 4'd3;
      4'b0111: grp = 4'd2;
      default: grp = 4'd1;
    endcase
  end

  AST_CD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_gcp_o[3:2] == 2'b01); // R1
  AST_NO_TAKE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !pix_ready_o); // R3
  AST_LINK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> link_valid_o); // R4
  AST_LINK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !link_valid_o); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_valid_o |-> link_sym_o == '0); // R4
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> tx_gcp_o[7:4] < grp); // R5
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_o && $past(link_valid_o)) |->
      tx_gcp_o[7:4] == (($past(tx_gcp_o[7:4]) == grp - 4'd1) ? 4'd0 : $past(tx_gcp_o[7:4]) + 4'd1)); // R5
  AST_PIX_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(link_valid_i)); // R7
  AST_RX_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_i && !$past(link_valid_i)) |=> rx_phase_o == '0); // R8
endmodule

bind dcg_gearbox dcg_gearbox_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .pix_ready_o(pix_ready_o),
  .link_sym_o(link_sym_o), .link_valid_o(link_valid_o), .tx_gcp_o(tx_gcp_o),
  .link_valid_i(link_valid_i), .pix_valid_o(pix_valid_o), .rx_phase_o(rx_phase_o)
);

// File: tb/dcg_gearbox_tb.sv
`timescale 1ns/1ps
module dcg_gearbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cd = 4'b0100;
  logic        tx_en = 1'b0;
  logic [47:0] pix = '0;
  logic        pix_ready, link_valid_o, pix_valid;
  logic [23:0] link_sym_o;
  logic [7:0]  gcp;
  logic [47:0] pix_out;
  logic [3:0]  rx_phase;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_link_q[$];
  logic [47:0] exp_pix_q[$];

  always #2.5 clk = ~clk;

  dcg_gearbox u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_cd_i(cd), .tx_en_i(tx_en), .pix_i(pix),
    .pix_ready_o(pix_ready), .link_sym_o(link_sym_o), .link_valid_o(link_valid_o),
    .tx_gcp_o(gcp), .rx_cd_i(cd), .link_valid_i(link_valid_o), .link_sym_i(link_sym_o),
    .pix_o(pix_out), .pix_valid_o(pix_valid), .rx_phase_o(rx_phase)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int dbits_of(input logic [3:0] c);
    case (c) 4'b0101: return 10; 4'b0110: return 12; 4'b0111: return 16; default: return 8; endcase
  endfunction
  function automatic int group_of(input logic [3:0] c);
    case (c) 4'b0101: return 5; 4'b0110: return 3; 4'b0111: return 2; default: return 1; endcase
  endfunction
  function automatic logic [3:0] code_of(input logic [3:0] c);
    return (c inside {4'b0101, 4'b0110, 4'b0111}) ? c : 4'b0100;
  endfunction

  // monitor: pops expected link bytes and pixels
  logic       prev_v = 1'b0;
  logic [3:0] prev_ph = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_v) check(rx_phase == prev_ph, "R8 rx phase", 64'(rx_phase), 64'(prev_ph));
        prev_v = 1'b0;
        if (link_valid_o) begin
          if (exp_link_q.size() == 0) check(1'b0, "R4 unexpected link byte", 64'(link_sym_o), 0);
          else begin
            logic [31:0] e;
            e = exp_link_q.pop_front();
            check(link_sym_o == e[23:0], "R2 link bytes", 64'(link_sym_o), 64'(e[23:0]));
            check(gcp[3:0] == e[27:24], "R1 depth code", 64'(gcp[3:0]), 64'(e[27:24]));
            check(gcp[7:4] == e[31:28], "R5 phase", 64'(gcp[7:4]), 64'(e[31:28]));
            prev_v = 1'b1;
            prev_ph = e[31:28];
          end
        end
        if (pix_valid) begin
          if (exp_pix_q.size() == 0) check(1'b0, "R7 unexpected pixel", 64'(pix_out), 0);
          else begin
            logic [47:0] p;
            p = exp_pix_q.pop_front();
            check(pix_out == p, "R7 pixel", 64'(pix_out), 64'(p));
          end
        end else begin
          check(pix_out == '0, "R7 idle pixel zero", 64'(pix_out), 0);
        end
      end
    end
  end

  // driver: one active period of n link cycles
  task automatic run_period(input logic [3:0] c, input int n, input int chg_at,
                            input logic [3:0] c2);
    int d, g, m, r, idx;
    logic [47:0]  px[64];
    logic [511:0] st[3];
    d = dbits_of(c);
    g = group_of(c);
    m = (8 * n + d - 1) / d;
    r = (8 * n) / d;
    @(negedge clk);
    cd = c;
    tx_en = 1'b0;
    @(negedge clk);
    for (int j = 0; j < 64; j++) px[j] = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    for (int ch = 0; ch < 3; ch++) begin
      st[ch] = '0;
      for (int j = 0; j < m; j++)
        for (int b = 0; b < d; b++) st[ch][j*d+b] = px[j][ch*16 + 16 - d + b];
    end
    for (int k = 0; k < n; k++)
      exp_link_q.push_back({4'(k % g), code_of(c), st[2][8*k +: 8], st[1][8*k +: 8], st[0][8*k +: 8]});
    for (int j = 0; j < r; j++) begin
      logic [47:0] e;
      for (int ch = 0; ch < 3; ch++)
        e[ch*16 +: 16] = (px[j][ch*16 +: 16] >> (16 - d)) << (16 - d);
      exp_pix_q.push_back(e);
    end
    idx = 0;
    for (int k = 0; k < n; k++) begin
      if (k == chg_at) cd = c2;  // R6: ignored until idle
      tx_en = 1'b1;
      pix = px[idx];
      #1;
      if (pix_ready) idx++;
      @(negedge clk);
    end
    tx_en = 1'b0;
    #1;
    check(!pix_ready, "R3 no take when idle", 64'(pix_ready), 0);
    check(idx == m, "R3 pixels consumed", 64'(idx), 64'(m));
    repeat (3) @(negedge clk);
    check(!link_valid_o && link_sym_o == '0, "R4 idle link", 64'(link_sym_o), 0);
    check(gcp[7:4] == 4'((n - 1) % g), "R5 held phase", 64'(gcp[7:4]), 64'((n - 1) % g));
    check(exp_link_q.size() == 0, "R2 all bytes seen", 64'(exp_link_q.size()), 0);
    check(exp_pix_q.size() == 0, "R7 all pixels seen", 64'(exp_pix_q.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pix_ready && !link_valid_o && !pix_valid, "R9 reset valids", 64'({pix_ready, link_valid_o, pix_valid}), 0);
    check(gcp == 8'h04, "R9 reset gcp", 64'(gcp), 64'h04);
    check(rx_phase == 4'd0, "R9 reset rx phase", 64'(rx_phase), 0);
    rst_n = 1'b1;
    run_period(4'b0100, 6, -1, 4'b0100);   // 8-bit
    run_period(4'b0101, 15, -1, 4'b0101);  // 10-bit, three groups
    run_period(4'b0110, 9, -1, 4'b0110);   // 12-bit
    run_period(4'b0111, 8, -1, 4'b0111);   // 16-bit
    run_period(4'b0101, 7, -1, 4'b0101);   // R8: ends mid group
    run_period(4'b0101, 10, -1, 4'b0101);  // R8: restarts at phase 0
    run_period(4'b1011, 5, -1, 4'b1011);   // R1: illegal code falls back
    run_period(4'b0110, 12, 5, 4'b0111);   // R6: mid-period code change
    run_period(4'b0111, 3, -1, 4'b0111);   // 16-bit, odd length
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule